// File: doc/BRIEF.md
# CAN Dual-Rate Bit Timing Generator

This block divides the system clock into time quanta and groups the quanta into CAN bits. It tells the protocol engine when to sample the bus (a sample-point strobe) and when each bit ends (an end-of-bit strobe). Two configuration sets are held. One is sized for the arbitration-rate (nominal) bit and one, with narrower fields, for the faster data-phase bit. The protocol engine raises a phase-select input when the frame has reached a bit-rate-switched data phase. The new set takes over at the next bit boundary. If an error is reported while the data set is in use, the block drops back to the nominal set on the next clock.

The configuration sets are captured only while the configuration-mode input is high. While it is high the timer is parked at the start of a bit. Resynchronisation follows the usual rules. A sampled bus edge in phase segment 1 stretches that segment. A sampled bus edge in phase segment 2 cuts that segment short. Both corrections are bounded by the resynchronisation jump width, and only one correction is made per bit. A hard-sync request restarts the bit from any position.

Top module: `can_bit_timer`

## Requirements
- R1: A quantum lasts P = prescale+1 clocks. A bit is one synchronisation quantum, then phase segment 1 of (seg1+1) quanta, then phase segment 2 of (seg2+1) quanta. Counting clock cycles from 0 at the first cycle after a hard sync, `bit_end` is high for exactly one cycle at cycle (seg1+seg2+3)*P-1, and again every (seg1+seg2+3)*P cycles after that.
- R2: `sample_pt` is high for one cycle at the last clock of phase segment 1. Without resynchronisation this is cycle (seg1+2)*P-1.
- R3: The data set (prescale 8 bits, segment 1 5 bits, segment 2 4 bits, jump width 4 bits, each field giving value+1) drives the timing while `data_rate_active` is 1. The value of `data_phase_sel` in the cycle where `bit_end` is high becomes `data_rate_active` on the next cycle. The bit that follows uses the selected set.
- R4: `err_det` while `data_rate_active` is 1 clears `data_rate_active` on the next cycle, and the current quantum restarts with the nominal prescaler at the same segment position. `err_det` while the nominal set is active has no effect.
- R5: Both configuration sets load from their inputs on every clock while `cfg_mode` is 1. At other times the inputs are ignored. While `cfg_mode` is 1 the bit is held at its start, no strobe is issued and the nominal set is selected.
- R6: `hard_sync` restarts the bit at the synchronisation quantum and the prescaler at zero, from any position. No strobe is issued in that cycle.
- R7: A `bus_edge` in segment-1 quantum q (counted from 0) lengthens segment 1 by min(q+1, SJW) quanta, where SJW = jump width field + 1.
- R8: A `bus_edge` in segment-2 quantum q ends the bit at the end of quantum max(q, L2-1-SJW), where L2 is the segment-2 length.
- R9: A `bus_edge` during the synchronisation quantum has no effect. After one accepted edge, further edges in the same bit are ignored. An edge that arrives in the last clock of a segment is dropped.
- R10: During reset the strobes and `data_rate_active` are 0, and every configuration field resets to 0. This gives a 3-clock bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 1 | Configuration mode: loads both sets, parks the timer |
| nom_prescale | input | 8 | Nominal quantum prescaler (value+1 clocks) |
| nom_seg1 | input | 8 | Nominal phase segment 1 (value+1 quanta) |
| nom_seg2 | input | 7 | Nominal phase segment 2 (value+1 quanta) |
| nom_sjw | input | 7 | Nominal jump width (value+1 quanta) |
| dat_prescale | input | 8 | Data-phase quantum prescaler (value+1 clocks) |
| dat_seg1 | input | 5 | Data-phase segment 1 (value+1 quanta) |
| dat_seg2 | input | 4 | Data-phase segment 2 (value+1 quanta) |
| dat_sjw | input | 4 | Data-phase jump width (value+1 quanta) |
| data_phase_sel | input | 1 | Requests the data set from the next bit |
| hard_sync | input | 1 | Restart the bit at the synchronisation quantum |
| err_det | input | 1 | Error indication; forces the nominal set |
| bus_edge | input | 1 | Sampled recessive-to-dominant edge strobe |
| sample_pt | output | 1 | One-clock sample-point strobe |
| bit_end | output | 1 | One-clock strobe on the last clock of a bit |
| data_rate_active | output | 1 | 1 while the data set drives the timing |

## Verification
The checker watches the rate indicator on every cycle. It confirms that the indicator rises only after an end-of-bit strobe with the select high, and falls only on configuration, on an error or at a bit boundary. It also confirms that an error in the data phase clears the indicator at once, and that neither strobe follows a hard sync or appears in configuration mode. It also confirms that the stored sets never change outside configuration mode. The exact strobe positions need the bench's scenarios: the period and sample-point formulas across swept nominal and data settings, the size of each resynchronisation correction under SJW limits, ignored edges, and the timing of the bit that follows a fallback or a hard sync.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
    parameter int BRP_W  = 8;
    parameter int NTS1_W = 8;
    parameter int NTS2_W = 7;
    parameter int NSJW_W = 7;
    parameter int DTS1_W = 5;
    parameter int DTS2_W = 4;
    parameter int DSJW_W = 4;

    localparam int Q_W   = NTS1_W + 1;
    localparam int ADJ_W = NSJW_W + 1;

    typedef struct packed {
        logic [BRP_W-1:0]  brp;
        logic [NTS1_W-1:0] tseg1;
        logic [NTS2_W-1:0] tseg2;
        logic [NSJW_W-1:0] sjw;
    } nom_cfg_t;

    typedef struct packed {
        logic [BRP_W-1:0]  brp;
        logic [DTS1_W-1:0] tseg1;
        logic [DTS2_W-1:0] tseg2;
        logic [DSJW_W-1:0] sjw;
    } dat_cfg_t;

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PH1  = 2'd1,
        SEG_PH2  = 2'd2
    } seg_e;

    function automatic nom_cfg_t widen_dat(input dat_cfg_t d);
        nom_cfg_t w;
        w.brp   = d.brp;
        w.tseg1 = NTS1_W'(d.tseg1);
        w.tseg2 = NTS2_W'(d.tseg2);
        w.sjw   = NSJW_W'(d.sjw);
        return w;
    endfunction

    function automatic logic [ADJ_W-1:0] sjw_quanta(input logic [NSJW_W-1:0] f);
        return {1'b0, f} + ADJ_W'(1);
    endfunction
endpackage

// File: rtl/cbt_cfg_regs.sv
module cbt_cfg_regs
    import cbt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cfg_mode,
    input  nom_cfg_t nom_in,
    input  dat_cfg_t dat_in,
    output nom_cfg_t nom_q,
    output dat_cfg_t dat_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            nom_q <= '0;
            dat_q <= '0;
        end else if (cfg_mode) begin
            nom_q <= nom_in;
            dat_q <= dat_in;
        end
    end
endmodule

// File: rtl/cbt_prescaler.sv
module cbt_prescaler
    import cbt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [BRP_W-1:0] brp,
    output logic             tick
);
    logic [BRP_W-1:0] cnt;

    assign tick = (cnt >= brp);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + BRP_W'(1);
        end
    end
endmodule

// File: rtl/cbt_seq.sv
module cbt_seq
    import cbt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hold,
    input  logic     tq,
    input  nom_cfg_t cfg,
    input  logic     bus_edge,
    output logic     sample_pt,
    output logic     bit_end
);
    seg_e             seg;
    logic [Q_W-1:0]   q;
    logic [ADJ_W-1:0] adj;
    logic             resynced;

    logic [ADJ_W-1:0] sjw_len;
    logic [Q_W-1:0]   q_inc;
    logic [ADJ_W-1:0] ext;
    logic             seg1_last;
    logic             seg2_last;
    logic             seg_done;

    assign sjw_len   = sjw_quanta(cfg.sjw);
    assign q_inc     = q + Q_W'(1);
    assign ext       = (q_inc >= Q_W'(sjw_len)) ? sjw_len : ADJ_W'(q_inc);
    assign seg1_last = (q >= (Q_W'(cfg.tseg1) + Q_W'(adj)));
    assign seg2_last = ((q + Q_W'(adj)) >= Q_W'(cfg.tseg2));

    assign sample_pt = tq && (seg == SEG_PH1) && seg1_last;
    assign bit_end   = tq && (seg == SEG_PH2) && seg2_last;
    assign seg_done  = sample_pt || bit_end;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            seg      <= SEG_SYNC;
            q        <= '0;
            adj      <= '0;
            resynced <= 1'b0;
        end else begin
            if (tq) begin
                case (seg)
                    SEG_SYNC: begin
                        seg <= SEG_PH1;
                        q   <= '0;
                    end
                    SEG_PH1: begin
                        if (seg1_last) begin
                            seg <= SEG_PH2;
                            q   <= '0;
                            adj <= '0;
                        end else begin
                            q <= q_inc;
                        end
                    end
                    default: begin
                        if (seg2_last) begin
                            seg      <= SEG_SYNC;
                            q        <= '0;
                            adj      <= '0;
                            resynced <= 1'b0;
                        end else begin
                            q <= q_inc;
                        end
                    end
                endcase
            end
            if (bus_edge && !resynced && !seg_done) begin
                if (seg == SEG_PH1) begin
                    adj      <= ext;
                    resynced <= 1'b1;
                end else if (seg == SEG_PH2) begin
                    adj      <= sjw_len;
                    resynced <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
    import cbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_mode,
    input  logic [BRP_W-1:0]  nom_prescale,
    input  logic [NTS1_W-1:0] nom_seg1,
    input  logic [NTS2_W-1:0] nom_seg2,
    input  logic [NSJW_W-1:0] nom_sjw,
    input  logic [BRP_W-1:0]  dat_prescale,
    input  logic [DTS1_W-1:0] dat_seg1,
    input  logic [DTS2_W-1:0] dat_seg2,
    input  logic [DSJW_W-1:0] dat_sjw,
    input  logic              data_phase_sel,
    input  logic              hard_sync,
    input  logic              err_det,
    input  logic              bus_edge,
    output logic              sample_pt,
    output logic              bit_end,
    output logic              data_rate_active
);
    nom_cfg_t nom_in, nom_q, act_cfg;
    dat_cfg_t dat_in, dat_q;
    logic     rate_data;
    logic     fallback;
    logic     restart;
    logic     tick_raw;
    logic     tq;

    assign nom_in = '{brp: nom_prescale, tseg1: nom_seg1, tseg2: nom_seg2, sjw: nom_sjw};
    assign dat_in = '{brp: dat_prescale, tseg1: dat_seg1, tseg2: dat_seg2, sjw: dat_sjw};

    cbt_cfg_regs u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_mode (cfg_mode),
        .nom_in   (nom_in),
        .dat_in   (dat_in),
        .nom_q    (nom_q),
        .dat_q    (dat_q)
    );

    assign act_cfg  = rate_data ? widen_dat(dat_q) : nom_q;
    assign fallback = err_det && rate_data;
    assign restart  = cfg_mode || hard_sync || fallback;

    cbt_prescaler u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .brp     (act_cfg.brp),
        .tick    (tick_raw)
    );

    assign tq = tick_raw && !restart;

    cbt_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .hold      (cfg_mode || hard_sync),
        .tq        (tq),
        .cfg       (act_cfg),
        .bus_edge  (bus_edge),
        .sample_pt (sample_pt),
        .bit_end   (bit_end)
    );

    always_ff @(posedge clk) begin
        if (rst || cfg_mode) begin
            rate_data <= 1'b0;
        end else if (fallback) begin
            rate_data <= 1'b0;
        end else if (bit_end) begin
            rate_data <= data_phase_sel;
        end
    end

    assign data_rate_active = rate_data;
endmodule

// File: rtl/cbt_checker.sv
module cbt_checker
    import cbt_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     cfg_mode,
    input logic     hard_sync,
    input logic     err_det,
    input logic     data_phase_sel,
    input logic     sample_pt,
    input logic     bit_end,
    input logic     data_rate_active,
    input nom_cfg_t nom_q,
    input dat_cfg_t dat_q
);
    assert_rate_rise_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(data_rate_active) |-> $past(bit_end && data_phase_sel));

    assert_rate_fall_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(data_rate_active) |-> $past(cfg_mode || err_det || (bit_end && !data_phase_sel)));

    assert_err_fallback_R4: assert property (@(posedge clk) disable iff (rst)
        (err_det && data_rate_active) |=> !data_rate_active);

    assert_cfg_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        cfg_mode |-> (!sample_pt && !bit_end));

    assert_cfg_nom_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !cfg_mode |=> $stable(nom_q));

    assert_cfg_dat_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !cfg_mode |=> $stable(dat_q));

    assert_hsync_restart_R6: assert property (@(posedge clk) disable iff (rst)
        hard_sync |=> (!sample_pt && !bit_end));

    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (rst)
        sample_pt |-> !bit_end);
endmodule

bind can_bit_timer cbt_checker u_chk (
    .clk              (clk),
    .rst              (rst),
    .cfg_mode         (cfg_mode),
    .hard_sync        (hard_sync),
    .err_det          (err_det),
    .data_phase_sel   (data_phase_sel),
    .sample_pt        (sample_pt),
    .bit_end          (bit_end),
    .data_rate_active (data_rate_active),
    .nom_q            (nom_q),
    .dat_q            (dat_q)
);

// File: tb/test_can_bit_timer.sv
module test_can_bit_timer;
    import cbt_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_mode = 1'b0;
    logic [BRP_W-1:0]  nom_prescale = '0;
    logic [NTS1_W-1:0] nom_seg1 = '0;
    logic [NTS2_W-1:0] nom_seg2 = '0;
    logic [NSJW_W-1:0] nom_sjw = '0;
    logic [BRP_W-1:0]  dat_prescale = '0;
    logic [DTS1_W-1:0] dat_seg1 = '0;
    logic [DTS2_W-1:0] dat_seg2 = '0;
    logic [DSJW_W-1:0] dat_sjw = '0;
    logic              data_phase_sel = 1'b0;
    logic              hard_sync = 1'b0;
    logic              err_det = 1'b0;
    logic              bus_edge = 1'b0;
    logic              sample_pt, bit_end, data_rate_active;

    always #4 clk = ~clk;

    can_bit_timer i_can_bit_timer (.*);

    int checks = 0;
    int fails  = 0;
    int s_pos[4];
    int e_pos[4];
    int n_s, n_e;
    logic rate_log[256];
    int edge_a, edge_b, err_at, hs_at;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic configure(input int nb, input int n1, input int n2, input int nj,
                             input int db, input int d1, input int d2, input int dj);
        @(posedge clk); #1;
        cfg_mode = 1'b1;
        nom_prescale = BRP_W'(nb); nom_seg1 = NTS1_W'(n1);
        nom_seg2 = NTS2_W'(n2); nom_sjw = NSJW_W'(nj);
        dat_prescale = BRP_W'(db); dat_seg1 = DTS1_W'(d1);
        dat_seg2 = DTS2_W'(d2); dat_sjw = DSJW_W'(dj);
        @(posedge clk);
        @(posedge clk); #1;
        cfg_mode = 1'b0;
    endtask

    task automatic clear_sched();
        edge_a = -1; edge_b = -1; err_at = -1; hs_at = -1;
    endtask

    task automatic sync_run(input int win);
        @(posedge clk); #1;
        hard_sync = 1'b1;
        @(posedge clk); #1;
        hard_sync = 1'b0;
        for (int i = 0; i < 4; i++) begin
            s_pos[i] = -1;
            e_pos[i] = -1;
        end
        n_s = 0; n_e = 0;
        for (int c = 0; c < win; c++) begin
            @(negedge clk);
            if (sample_pt) begin
                if (n_s < 4) s_pos[n_s] = c;
                n_s++;
            end
            if (bit_end) begin
                if (n_e < 4) e_pos[n_e] = c;
                n_e++;
            end
            rate_log[c] = data_rate_active;
            bus_edge  = (c == edge_a) || (c == edge_b);
            err_det   = (c == err_at);
            hard_sync = (c == hs_at);
        end
        @(negedge clk);
        bus_edge = 1'b0; err_det = 1'b0; hard_sync = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        clear_sched();
        repeat (3) @(negedge clk);
        // R10: quiet outputs while in reset
        check("R10 sample_pt in reset", int'(sample_pt), 0);
        check("R10 bit_end in reset", int'(bit_end), 0);
        check("R10 rate in reset", int'(data_rate_active), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        // R10: zero configuration gives a 3-clock bit
        sync_run(10);
        check("R10 default sample", s_pos[0], 1);
        check("R10 default bit_end", e_pos[0], 2);
        check("R10 default period", e_pos[1], 5);

        // R1 R2: nominal sweep
        for (int b = 0; b < 3; b++)
            for (int t1 = 0; t1 < 4; t1++)
                for (int t2 = 0; t2 < 4; t2++) begin
                    int p, n;
                    p = b + 1;
                    n = (t1 + t2 + 3) * p;
                    configure(b, t1, t2, 0, 0, 0, 0, 0);
                    clear_sched();
                    sync_run(2 * n + 2);
                    check("R2 nominal sample point", s_pos[0], (t1 + 2) * p - 1);
                    check("R1 nominal first bit_end", e_pos[0], n - 1);
                    check("R1 nominal period", e_pos[1], 2 * n - 1);
                end

        // R3: data-rate sweep, nominal bit of 6 clocks first
        data_phase_sel = 1'b1;
        for (int b = 0; b < 2; b++)
            for (int t1 = 0; t1 < 3; t1++)
                for (int t2 = 0; t2 < 3; t2++) begin
                    int pd, nd;
                    pd = b + 1;
                    nd = (t1 + t2 + 3) * pd;
                    configure(0, 2, 1, 0, b, t1, t2, 0);
                    clear_sched();
                    sync_run(6 + nd + 2);
                    check("R3 rate before boundary", int'(rate_log[5]), 0);
                    check("R3 rate after boundary", int'(rate_log[6]), 1);
                    check("R3 data sample point", s_pos[1], 6 + (t1 + 2) * pd - 1);
                    check("R3 data bit_end", e_pos[1], 5 + nd);
                end

        // R4: error in data phase at start of data bit
        configure(1, 3, 2, 0, 0, 1, 1, 0);
        clear_sched();
        err_at = 16;
        sync_run(40);
        check("R4 rate during data bit", int'(rate_log[16]), 1);
        check("R4 rate after error", int'(rate_log[17]), 0);
        check("R4 nominal sample after fallback", s_pos[1], 26);
        check("R4 nominal bit_end after fallback", e_pos[1], 32);

        // R4: error while nominal has no effect
        data_phase_sel = 1'b0;
        configure(1, 3, 2, 0, 0, 1, 1, 0);
        clear_sched();
        err_at = 5;
        sync_run(34);
        check("R4 nominal err sample", s_pos[0], 9);
        check("R4 nominal err bit_end", e_pos[0], 15);
        check("R4 nominal err period", e_pos[1], 31);
        check("R4 nominal err rate", int'(rate_log[6]), 0);

        // R5: inputs ignored outside configuration mode
        configure(0, 1, 1, 0, 0, 0, 0, 0);
        @(posedge clk); #1;
        nom_prescale = 8'd3; nom_seg1 = 8'd9; nom_seg2 = 7'd9;
        clear_sched();
        sync_run(12);
        check("R5 ignored write bit_end", e_pos[0], 4);
        check("R5 ignored write sample", s_pos[0], 2);

        // R5: held while configuration mode is high
        @(posedge clk); #1;
        cfg_mode = 1'b1;
        data_phase_sel = 1'b1;
        n_s = 0; n_e = 0;
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (sample_pt) n_s++;
            if (bit_end) n_e++;
            if (data_rate_active) n_s++;
        end
        check("R5 no strobes in cfg mode", n_s + n_e, 0);
        @(posedge clk); #1;
        cfg_mode = 1'b0;
        data_phase_sel = 1'b0;

        // R6: hard sync in the middle of segment 2
        configure(1, 3, 2, 0, 0, 0, 0, 0);
        clear_sched();
        hs_at = 12;
        sync_run(34);
        check("R6 sample before hard sync", s_pos[0], 9);
        check("R6 restarted sample", s_pos[1], 22);
        check("R6 restarted bit_end", e_pos[0], 28);

        // R7: segment-1 lengthening
        configure(1, 5, 3, 1, 0, 0, 0, 0);
        clear_sched(); edge_a = 2;
        sync_run(30);
        check("R7 edge q0 sample", s_pos[0], 15);
        check("R7 edge q0 bit_end", e_pos[0], 23);
        clear_sched(); edge_a = 8;
        sync_run(30);
        check("R7 edge q3 sjw-limited sample", s_pos[0], 17);
        check("R7 edge q3 sjw-limited bit_end", e_pos[0], 25);
        configure(1, 5, 3, 7, 0, 0, 0, 0);
        clear_sched(); edge_a = 8;
        sync_run(34);
        check("R7 edge q3 wide sjw sample", s_pos[0], 21);
        check("R7 edge q3 wide sjw bit_end", e_pos[0], 29);

        // R8: segment-2 shortening
        configure(1, 5, 3, 1, 0, 0, 0, 0);
        clear_sched(); edge_a = 14;
        sync_run(30);
        check("R8 edge q0 bit_end", e_pos[0], 17);
        check("R8 edge q0 sample unchanged", s_pos[0], 13);
        clear_sched(); edge_a = 18;
        sync_run(30);
        check("R8 edge q2 bit_end", e_pos[0], 19);
        configure(1, 5, 3, 0, 0, 0, 0, 0);
        clear_sched(); edge_a = 14;
        sync_run(30);
        check("R8 edge q0 sjw1 bit_end", e_pos[0], 19);

        // R9: ignored edges
        configure(1, 5, 3, 1, 0, 0, 0, 0);
        clear_sched(); edge_a = 0;
        sync_run(30);
        check("R9 sync-quantum edge sample", s_pos[0], 13);
        check("R9 sync-quantum edge bit_end", e_pos[0], 21);
        clear_sched(); edge_a = 2; edge_b = 8;
        sync_run(30);
        check("R9 second edge sample", s_pos[0], 15);
        check("R9 second edge bit_end", e_pos[0], 23);
        clear_sched(); edge_a = 13;
        sync_run(30);
        check("R9 last-clock edge bit_end", e_pos[0], 21);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule